// File: doc/BRIEF.md
# Clear-On-Read Interrupt Aggregator

This block gathers seven event sources of a radio transceiver into one latched status word and drives a single active-low interrupt request line toward a host processor. The sources are: power-on, low supply, wake-up timeout, a falling edge on an external active-low interrupt pin, a shared overflow/underrun condition, receive-threshold reached and transmit-ready. Each source sets its own sticky bit. The request line is held low while any bit is pending.

The host reads the status word when it samples the status output in the cycle it pulses the read strobe. The latched bits clear at the next clock edge. An event that arrives in that same cycle is not lost: it is latched for the next read. The shared bit reflects FIFO overflow while the transmit/receive flag selects receive, and transmit register underrun while it selects transmit. The external pin is resynchronized before its falling edge is detected.

Top module: `irq_hub`

## Requirements
- R1: While reset is high, status_o is all zeros and irq_n_o is 1.
- R2: In the first cycle after reset is released, status bit 0 (power-on) becomes set and irq_n_o goes low, one clock edge after the first cycle with reset low.
- R3: A one-cycle pulse on a source input sets its status bit at the next edge: low_vdd_i to bit 1, wake_i to bit 2, rx_thr_i to bit 5, tx_rdy_i to bit 6.
- R4: Bit 4 is set by fifo_ovf_i only while tx_mode_i is 0 (receive), and by tx_undr_i only while tx_mode_i is 1 (transmit). The other input of the pair has no effect on bit 4 in that mode.
- R5: A falling edge on ext_irq_n_i sets bit 3 exactly SYNC_STAGES+1 edges after the pin is first sampled low. A pin that stays low, or a rising edge, sets nothing more.
- R6: A set bit stays set on every edge where rd_stb_i is low.
- R7: An edge with rd_stb_i high clears every bit, except the bits whose events arrive in that same cycle. Those bits are set after that edge.
- R8: irq_n_o is low exactly when any status bit is set. It returns high at the edge of a read that leaves no bit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_rdy_i | input | 1 | Pulse: transmit register ready for next byte |
| rx_thr_i | input | 1 | Pulse: receive FIFO reached programmed bit count |
| fifo_ovf_i | input | 1 | Pulse: receive FIFO overflow |
| tx_undr_i | input | 1 | Pulse: transmit register underrun |
| wake_i | input | 1 | Pulse: wake-up timer timeout |
| low_vdd_i | input | 1 | Pulse: supply below threshold |
| ext_irq_n_i | input | 1 | Asynchronous active-low external interrupt pin |
| tx_mode_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| rd_stb_i | input | 1 | Status read strobe, one cycle per read |
| irq_n_o | output | 1 | Active-low interrupt request |
| status_o | output | 7 | Latched event bits (bit map in R3 to R5) |

## Verification
The bench builds the block with SYNC_STAGES = 2, the smallest legal synchronizer depth. This places the external-pin detection at exactly three edges, so a directed check can sample just before and just after that edge. Random mode flips with sparse pulses and reads cover reads that collide with events in the same cycle and the mode gating of the shared bit. Its reference model is parameterized on the same depth.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int SRC_N = 7;

  localparam int B_POR   = 0;
  localparam int B_LOWV  = 1;
  localparam int B_WAKE  = 2;
  localparam int B_EXT   = 3;
  localparam int B_XRUN  = 4;
  localparam int B_RXTH  = 5;
  localparam int B_TXRDY = 6;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_n_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // idle level of the pin is high, so reset fills the chain with ones
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[LAST-1:0], pin_n_i};
      prev_q <= sh_q[LAST];
    end
  end

  assign fall_o = prev_q & ~sh_q[LAST];

  // R5: a held-low pin produces only one detection
  a_r5_single_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_o |=> !fall_o);
endmodule

// File: rtl/irq_hub_latch.sv
module irq_hub_latch #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o,
  output logic         any_o
);
  logic [N-1:0] nxt;
  logic         any_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign nxt[g] = set_i[g] | (q_o[g] & ~clr_i);
    always_ff @(posedge clk_i) begin
      if (rst_i) q_o[g] <= 1'b0;
      else       q_o[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) any_q <= 1'b0;
    else       any_q <= |nxt;
  end
  assign any_o = any_q;

  // R6: bits are sticky between reads
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));
  // R7: a read keeps exactly the events of its own cycle
  a_r7_read_keeps_new: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (q_o == $past(set_i)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tx_rdy_i,
  input  logic             rx_thr_i,
  input  logic             fifo_ovf_i,
  input  logic             tx_undr_i,
  input  logic             wake_i,
  input  logic             low_vdd_i,
  input  logic             ext_irq_n_i,
  input  logic             tx_mode_i,
  input  logic             rd_stb_i,
  output logic             irq_n_o,
  output logic [SRC_N-1:0] status_o
);
  logic     por_arm_q;
  logic     ext_fall;
  logic     any_pend;
  src_vec_t set_vec;

  // armed during reset, fires once in the first cycle after release
  always_ff @(posedge clk_i) begin
    if (rst_i) por_arm_q <= 1'b1;
    else       por_arm_q <= 1'b0;
  end

  irq_hub_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .pin_n_i (ext_irq_n_i),
    .fall_o  (ext_fall)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_POR]   = por_arm_q;
    set_vec[B_LOWV]  = low_vdd_i;
    set_vec[B_WAKE]  = wake_i;
    set_vec[B_EXT]   = ext_fall;
    set_vec[B_XRUN]  = tx_mode_i ? tx_undr_i : fifo_ovf_i;
    set_vec[B_RXTH]  = rx_thr_i;
    set_vec[B_TXRDY] = tx_rdy_i;
  end

  irq_hub_latch #(.N(SRC_N)) u_latch (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .set_i (set_vec),
    .clr_i (rd_stb_i),
    .q_o   (status_o),
    .any_o (any_pend)
  );

  assign irq_n_o = ~any_pend;

  // R8: request line mirrors pending status
  a_r8_irq_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_n_o == ~(|status_o));
  // R2: power-on bit after reset release
  a_r2_por_bit: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |=> status_o[B_POR]);
  // R4: underrun counts in transmit mode
  a_r4_undr_tx: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_mode_i && tx_undr_i) |=> status_o[B_XRUN]);
  // R4: overflow counts in receive mode
  a_r4_ovf_rx: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tx_mode_i && fifo_ovf_i) |=> status_o[B_XRUN]);
  // R7: a read with no new event empties the word
  a_r7_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_stb_i && !(|set_vec)) |=> (status_o == '0));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int SYNC = 2;
  localparam int W    = 7;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic tx_rdy_i = 0, rx_thr_i = 0, fifo_ovf_i = 0, tx_undr_i = 0;
  logic wake_i = 0, low_vdd_i = 0, ext_irq_n_i = 1, tx_mode_i = 0, rd_stb_i = 0;
  logic         irq_n_o;
  logic [W-1:0] status_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  logic [W-1:0]    m_st;
  logic [SYNC-1:0] m_sh;
  logic            m_prev, m_por;

  always #10 clk = ~clk;

  irq_hub #(.SYNC_STAGES(SYNC)) u_irq_hub (
    .clk_i(clk), .rst_i(rst_i), .tx_rdy_i(tx_rdy_i), .rx_thr_i(rx_thr_i),
    .fifo_ovf_i(fifo_ovf_i), .tx_undr_i(tx_undr_i), .wake_i(wake_i),
    .low_vdd_i(low_vdd_i), .ext_irq_n_i(ext_irq_n_i), .tx_mode_i(tx_mode_i),
    .rd_stb_i(rd_stb_i), .irq_n_o(irq_n_o), .status_o(status_o));

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_set(input logic [5:0] ev, input logic mode,
                                             input logic fall, input logic por);
    logic [W-1:0] s;
    s    = '0;
    s[0] = por;
    s[1] = ev[0];
    s[2] = ev[1];
    s[3] = fall;
    s[4] = mode ? ev[5] : ev[4];
    s[5] = ev[2];
    s[6] = ev[3];
    return s;
  endfunction

  // ev: [0]=low_vdd [1]=wake [2]=rx_thr [3]=tx_rdy [4]=fifo_ovf [5]=tx_undr
  task automatic step(input logic [5:0] ev, input logic pin, input logic mode,
                      input logic rd, input string tag);
    logic fall;
    low_vdd_i = ev[0]; wake_i = ev[1]; rx_thr_i = ev[2]; tx_rdy_i = ev[3];
    fifo_ovf_i = ev[4]; tx_undr_i = ev[5];
    ext_irq_n_i = pin; tx_mode_i = mode; rd_stb_i = rd;
    @(posedge clk);
    fall = m_prev & ~m_sh[SYNC-1];
    m_st = (rd ? '0 : m_st) | model_set(ev, mode, fall, m_por);
    m_prev = m_sh[SYNC-1];
    m_sh = {m_sh[SYNC-2:0], pin};
    m_por = 1'b0;
    @(negedge clk);
    chk(status_o === m_st, {tag, " status"}, status_o, m_st);
    chk(irq_n_o === ~(|m_st), {tag, " R8 irq"}, {6'b0, irq_n_o}, {6'b0, ~(|m_st)});
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog R1 actual=%b expected=%b", 1'b0, 1'b1);
    bad++; total++;
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_st = '0; m_sh = '1; m_prev = 1'b1; m_por = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(status_o === '0, "R1 status in reset", status_o, '0);
    chk(irq_n_o === 1'b1, "R1 irq in reset", {6'b0, irq_n_o}, 7'd1);
    rst_i = 1'b0;
    // R2: power-on bit after release
    step(6'b0, 1, 0, 0, "R2");
    chk(status_o === 7'b000_0001, "R2 por bit", status_o, 7'b000_0001);
    chk(irq_n_o === 1'b0, "R2 irq low", {6'b0, irq_n_o}, 7'd0);
    // R6: sticky without read
    repeat (4) step(6'b0, 1, 0, 0, "R6");
    chk(status_o[0] === 1'b1, "R6 por kept", status_o, 7'b000_0001);
    // R7/R8: clearing read
    step(6'b0, 1, 0, 1, "R7");
    chk(status_o === '0, "R7 cleared", status_o, '0);
    chk(irq_n_o === 1'b1, "R8 irq high after read", {6'b0, irq_n_o}, 7'd1);
    // R3: each pulse source
    for (int k = 0; k < 4; k++) begin
      step(6'(1 << k), 1, 0, 0, "R3");
      step(6'b0, 1, 0, 1, "R3 read");
    end
    // R4: mode gating of shared bit
    step(6'b10_0000, 1, 0, 0, "R4 undr in rx");
    chk(status_o[4] === 1'b0, "R4 undr ignored in rx", status_o, '0);
    step(6'b01_0000, 1, 1, 0, "R4 ovf in tx");
    chk(status_o[4] === 1'b0, "R4 ovf ignored in tx", status_o, '0);
    step(6'b10_0000, 1, 1, 0, "R4 undr in tx");
    chk(status_o[4] === 1'b1, "R4 undr sets in tx", status_o, 7'b001_0000);
    step(6'b0, 1, 1, 1, "R4 read");
    step(6'b01_0000, 1, 0, 0, "R4 ovf in rx");
    chk(status_o[4] === 1'b1, "R4 ovf sets in rx", status_o, 7'b001_0000);
    step(6'b0, 1, 0, 1, "R4 read");
    // R5: external falling edge timing
    step(6'b0, 0, 0, 0, "R5 e1");
    step(6'b0, 0, 0, 0, "R5 e2");
    chk(status_o[3] === 1'b0, "R5 not yet", status_o, '0);
    step(6'b0, 0, 0, 0, "R5 e3");
    chk(status_o[3] === 1'b1, "R5 edge seen", status_o, 7'b000_1000);
    step(6'b0, 0, 0, 1, "R5 read");
    repeat (4) step(6'b0, 0, 0, 0, "R5 held low");
    chk(status_o === '0, "R5 held low no retrigger", status_o, '0);
    repeat (4) step(6'b0, 1, 0, 0, "R5 rising");
    chk(status_o === '0, "R5 rising ignored", status_o, '0);
    // R7: event on the read cycle survives
    step(6'b00_0010, 1, 0, 0, "R7 pre");
    step(6'b00_1000, 1, 0, 1, "R7 same cycle");
    chk(status_o === 7'b100_0000, "R7 new event kept", status_o, 7'b100_0000);
    step(6'b0, 1, 0, 1, "R7 read2");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ev;
      for (int b = 0; b < 6; b++) ev[b] = ($urandom_range(0, 9) == 0);
      step(ev, ($urandom_range(0, 5) != 0), ($urandom_range(0, 19) == 0) ? ~tx_mode_i : tx_mode_i,
           ($urandom_range(0, 6) == 0), "R3 R4 R5 R6 R7 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule